// File: doc/BRIEF.md
# Display Identification Block Reader

This block fetches one 128-byte display identification block from a monitor over the two-wire display data channel. A host gives it a block number and a one-cycle start strobe. The block then drives a byte-level two-wire master through a simple command handshake. That master handles the bit timing and arbitration; this block only decides which bus events happen and in what order.

Each block number maps to a segment and a word offset. The segment is the block number divided by two. The word offset is 0x80 when the block number is odd and 0x00 when it is even. A segment is sent through the segment-pointer device only when it is non-zero. This keeps older sinks working, since they have no segment pointer and would reject that address. The offset is then written to the data device, the bus turns around with a repeated start, and the 128 bytes are read. Every byte received goes out on a stream with its index.

The block stops on the first refused address or data byte. It issues a stop, reports an error and delivers no data. A successful read ends with a done pulse.

Top module: `ddc_block_reader`

## Requirements
- R1: After reset, busy, done, error, rx_valid and cmd_valid are all low. No command is issued while busy is low.
- R2: The segment is the block number shifted right by one. The word offset is 0x80 for odd block numbers and 0x00 for even ones.
- R3: For block numbers 0 and 1, the command sequence is START, WRITE 0xA0, WRITE offset, START, WRITE 0xA1, 128 READs, STOP. No segment-pointer write is issued.
- R4: For block numbers 2 and above, the sequence begins START, WRITE 0x60, WRITE segment. It then continues with START and the rest of the R3 sequence.
- R5: cmd_rnack is 0 on the first 127 READ commands and 1 on the 128th.
- R6: The cycle after the cmd_done of a READ, rx_valid pulses for one cycle. It carries the received byte on rx_data and its index on rx_index, and the indexes run 0 to 127 in order.
- R7: The cycle after the STOP of a successful read completes, done pulses for one cycle and busy falls in that same cycle.
- R8: A cmd_nack on any WRITE makes the next command a STOP, with no further WRITE or READ. The cycle after that STOP completes, error pulses and busy falls. done and rx_valid stay low for the rest of that request.
- R9: A start strobe while busy is high is ignored, and the request already running continues unchanged.
- R10: Command encoding on cmd_op: 0 = START (or repeated start), 1 = WRITE cmd_wdata, 2 = READ, 3 = STOP. cmd_op, cmd_wdata and cmd_rnack hold steady while cmd_valid is high and cmd_done is low. cmd_valid is low in the cycle after cmd_done.
- R11: cmd_nack is ignored on START, READ and STOP commands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request strobe, accepted only while idle |
| block | input | BLK_W | Block number, captured with start |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle pulse: block read successfully |
| error | output | 1 | One-cycle pulse: request ended on a refused byte |
| rx_valid | output | 1 | One-cycle strobe for a received byte |
| rx_index | output | IDX_W | Index of the byte on rx_data |
| rx_data | output | 8 | Received byte |
| cmd_valid | output | 1 | Command to the two-wire master is pending |
| cmd_op | output | 2 | Command code: 0 START, 1 WRITE, 2 READ, 3 STOP |
| cmd_wdata | output | 8 | Byte for a WRITE command |
| cmd_rnack | output | 1 | On a READ: 1 = answer with NACK |
| cmd_done | input | 1 | One-cycle completion of the pending command |
| cmd_nack | input | 1 | With cmd_done on a WRITE: the byte was refused |
| cmd_rdata | input | 8 | With cmd_done on a READ: the received byte |

## Verification
Each result has a fixed due time, measured from the cycle where its cause is driven:

- rx_valid follows a READ's cmd_done by exactly one cycle.
- done or error follows the STOP's cmd_done by exactly one cycle.
- cmd_valid rises one cycle after the previous completion.

The bench drives the master model on falling edges and samples the outputs on the next falling edge. It therefore checks each strobe at the exact cycle it is due and flags any strobe seen at another time. It also logs the full command trace and compares it with a sequence rebuilt from the block number and the injected refusal position.

// File: rtl/ddc_block_reader.sv
module ddc_block_reader #(
  parameter int          BLK_W     = 8,
  parameter int          BLK_BYTES = 128,
  parameter logic [6:0]  DATA_DEV  = 7'h50,
  parameter logic [6:0]  SEG_DEV   = 7'h30
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 start,
  input  logic [BLK_W-1:0]                     block,
  output logic                                 busy,
  output logic                                 done,
  output logic                                 error,
  output logic                                 rx_valid,
  output logic [$clog2(BLK_BYTES)-1:0]         rx_index,
  output logic [7:0]                           rx_data,
  output logic                                 cmd_valid,
  output logic [1:0]                           cmd_op,
  output logic [7:0]                           cmd_wdata,
  output logic                                 cmd_rnack,
  input  logic                                 cmd_done,
  input  logic                                 cmd_nack,
  input  logic [7:0]                           cmd_rdata
);
  localparam int         IDX_W   = $clog2(BLK_BYTES);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BLK_BYTES - 1);
  localparam logic [7:0] ODD_OFS = 8'(BLK_BYTES);
  localparam logic [1:0] OP_START = 2'd0, OP_WRITE = 2'd1, OP_READ = 2'd2, OP_STOP = 2'd3;

  typedef enum logic [3:0] {
    ST_IDLE, ST_SSTART, ST_SADDR, ST_SVAL, ST_WSTART, ST_WADDR,
    ST_WOFS, ST_RSTART, ST_RADDR, ST_READ, ST_STOP
  } st_t;

  st_t              st;
  logic [BLK_W-1:0] blk;
  logic [IDX_W-1:0] rd_cnt;
  logic             fail_pend;

  wire [7:0] seg_byte = 8'(blk >> 1);
  wire [7:0] ofs_byte = blk[0] ? ODD_OFS : 8'h00;
  wire       xfer_end = cmd_valid && cmd_done;

  assign busy = (st != ST_IDLE);

  always_comb begin
    cmd_op    = OP_START;
    cmd_wdata = 8'h00;
    cmd_rnack = 1'b0;
    case (st)
      ST_SADDR: begin cmd_op = OP_WRITE; cmd_wdata = {SEG_DEV, 1'b0};  end
      ST_SVAL:  begin cmd_op = OP_WRITE; cmd_wdata = seg_byte;         end
      ST_WADDR: begin cmd_op = OP_WRITE; cmd_wdata = {DATA_DEV, 1'b0}; end
      ST_WOFS:  begin cmd_op = OP_WRITE; cmd_wdata = ofs_byte;         end
      ST_RADDR: begin cmd_op = OP_WRITE; cmd_wdata = {DATA_DEV, 1'b1}; end
      ST_READ:  begin cmd_op = OP_READ;  cmd_rnack = (rd_cnt == LAST_IDX); end
      ST_STOP:  cmd_op = OP_STOP;
      default:  cmd_op = OP_START;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      blk       <= '0;
      rd_cnt    <= '0;
      fail_pend <= 1'b0;
      cmd_valid <= 1'b0;
      done      <= 1'b0;
      error     <= 1'b0;
      rx_valid  <= 1'b0;
      rx_index  <= '0;
      rx_data   <= 8'h00;
    end else begin
      done     <= 1'b0;
      error    <= 1'b0;
      rx_valid <= 1'b0;
      if (st == ST_IDLE) begin
        if (start) begin
          blk       <= block;
          rd_cnt    <= '0;
          fail_pend <= 1'b0;
          st        <= ((block >> 1) != '0) ? ST_SSTART : ST_WSTART;
        end
      end else if (!cmd_valid) begin
        cmd_valid <= 1'b1;
      end else if (cmd_done) begin
        cmd_valid <= 1'b0;
        if (cmd_op == OP_WRITE && cmd_nack) begin
          fail_pend <= 1'b1;
          st        <= ST_STOP;
        end else begin
          case (st)
            ST_SSTART: st <= ST_SADDR;
            ST_SADDR:  st <= ST_SVAL;
            ST_SVAL:   st <= ST_WSTART;
            ST_WSTART: st <= ST_WADDR;
            ST_WADDR:  st <= ST_WOFS;
            ST_WOFS:   st <= ST_RSTART;
            ST_RSTART: st <= ST_RADDR;
            ST_RADDR:  st <= ST_READ;
            ST_READ: begin
              rx_valid <= 1'b1;
              rx_data  <= cmd_rdata;
              rx_index <= rd_cnt;
              rd_cnt   <= rd_cnt + 1'b1;
              if (rd_cnt == LAST_IDX) st <= ST_STOP;
            end
            ST_STOP: begin
              st    <= ST_IDLE;
              done  <= !fail_pend;
              error <= fail_pend;
            end
            default: st <= ST_IDLE;
          endcase
        end
      end
    end
  end

  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_done |=> cmd_valid && $stable(cmd_op) && $stable(cmd_wdata) && $stable(cmd_rnack)); // R10
  AST_CMD_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_end |=> !cmd_valid); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !cmd_valid && !rx_valid); // R1
  AST_RX_IN_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> busy && !done && !error); // R6
  AST_END_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && error)); // R8
  AST_END_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done || error |-> !busy); // R7
  AST_END_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7
endmodule

// File: tb/tb_ddc_block_reader.sv
module tb_ddc_block_reader;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [7:0] block = 8'h00;
  logic busy, done, error, rx_valid, cmd_valid, cmd_rnack;
  logic [6:0] rx_index;
  logic [7:0] rx_data, cmd_wdata;
  logic [1:0] cmd_op;
  logic cmd_done = 1'b0, cmd_nack = 1'b0;
  logic [7:0] cmd_rdata = 8'h00;

  ddc_block_reader dut (
    .clk(clk), .rst_n(rst_n), .start(start), .block(block), .busy(busy),
    .done(done), .error(error), .rx_valid(rx_valid), .rx_index(rx_index),
    .rx_data(rx_data), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_wdata(cmd_wdata), .cmd_rnack(cmd_rnack), .cmd_done(cmd_done),
    .cmd_nack(cmd_nack), .cmd_rdata(cmd_rdata));

  always #4 clk = ~clk;

  int total = 0, bad = 0;
  int cur_blk, nack_at, wr_idx, rd_idx, rx_cnt, dly, tr_n;
  int tr_op [0:255];
  int tr_dat[0:255];
  int ex_op [0:255];
  int ex_dat[0:255];
  int ex_n, ex_nw;
  bit ex_cut, exp_err, txn_end, last_read, last_stop, hold_on;
  logic [1:0] hold_op;
  logic [7:0] hold_wd;

  function automatic logic [7:0] pat(int b, int i);
    return 8'((b * 7 + i * 13) ^ 8'h3C);
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rx_valid || last_read) begin
      chk(rx_valid && last_read && rx_index == 7'(rx_cnt) && rx_data == pat(cur_blk, rx_cnt),
          "R6", "rx byte", {rx_valid, last_read, 1'b0, rx_index, rx_data},
          {2'b11, 1'b0, 7'(rx_cnt), pat(cur_blk, rx_cnt)});
      rx_cnt++;
    end
    if (done || error || last_stop) begin
      chk(done == (last_stop && !exp_err) && error == (last_stop && exp_err) && !busy,
          exp_err ? "R8" : "R7", "end pulse", {done, error, busy}, {!exp_err, exp_err, 1'b0});
      if (last_stop) txn_end = 1'b1;
    end
    if (hold_on && cmd_valid && (cmd_op != hold_op || (cmd_op == 2'd1 && cmd_wdata != hold_wd)))
      chk(1'b0, "R10", "hold", {cmd_op, cmd_wdata}, {hold_op, hold_wd});
    cmd_done  = 1'b0;
    cmd_nack  = 1'b0;
    last_read = 1'b0;
    last_stop = 1'b0;
    hold_on   = 1'b0;
    if (rst_n && cmd_valid) begin
      if (dly > 0) begin
        dly--;
        hold_on = 1'b1; hold_op = cmd_op; hold_wd = cmd_wdata;
      end else begin
        cmd_done = 1'b1;
        tr_op[tr_n] = int'(cmd_op);
        tr_dat[tr_n] = (cmd_op == 2'd1) ? int'(cmd_wdata) : (cmd_op == 2'd2) ? int'(cmd_rnack) : 0;
        if (tr_n < 255) tr_n++;
        if (cmd_op == 2'd1) begin
          cmd_nack = (wr_idx == nack_at);
          wr_idx++;
        end else begin
          cmd_nack = 1'($urandom % 2); // R11 noise on non-write ops
        end
        if (cmd_op == 2'd2) begin
          cmd_rdata = pat(cur_blk, rd_idx);
          rd_idx++;
          last_read = 1'b1;
        end
        if (cmd_op == 2'd3) last_stop = 1'b1;
        dly = int'($urandom % 3);
      end
    end
  end

  task automatic push(int op, int dat, bit force_it);
    if (!ex_cut || force_it) begin
      ex_op[ex_n] = op; ex_dat[ex_n] = dat; ex_n++;
      if (op == 1 && !force_it) begin
        if (ex_nw == nack_at) ex_cut = 1'b1;
        ex_nw++;
      end
    end
  endtask

  task automatic run_txn(int b, int nk, bit poke);
    int seg, ofs, guard, mism;
    seg = b >> 1;
    ofs = (b & 1) ? 8'h80 : 8'h00;
    ex_n = 0; ex_nw = 0; ex_cut = 1'b0; nack_at = nk;
    push(0, 0, 0);
    if (seg != 0) begin push(1, 8'h60, 0); push(1, seg, 0); push(0, 0, 0); end
    push(1, 8'hA0, 0); push(1, ofs, 0); push(0, 0, 0); push(1, 8'hA1, 0);
    for (int i = 0; i < 128; i++) push(2, (i == 127) ? 1 : 0, 0);
    exp_err = ex_cut;
    if (ex_cut) push(3, 0, 1); else push(3, 0, 0);
    cur_blk = b; wr_idx = 0; rd_idx = 0; rx_cnt = 0; tr_n = 0; txn_end = 1'b0;
    @(negedge clk); start = 1'b1; block = 8'(b);
    @(negedge clk); start = 1'b0; block = 8'(b ^ 8'hFF);
    if (poke) begin
      repeat (15) @(negedge clk);
      start = 1'b1; block = 8'(b ^ 8'h5A);
      @(negedge clk); start = 1'b0;
    end
    guard = 0;
    while (!txn_end && guard < 4000) begin @(negedge clk); guard++; end
    chk(txn_end, "R7", "request finished", guard, 0);
    mism = -1;
    for (int i = 0; i < ex_n; i++)
      if (mism < 0 && (tr_op[i] != ex_op[i] || tr_dat[i] != ex_dat[i])) mism = i;
    chk(tr_n == ex_n, (seg != 0) ? "R4" : "R3", "command count", tr_n, ex_n);
    if (mism >= 0)
      chk(1'b0, exp_err ? "R8" : ((seg != 0) ? "R4" : "R3"), $sformatf("command %0d", mism),
          (tr_op[mism] << 8) | tr_dat[mism], (ex_op[mism] << 8) | ex_dat[mism]);
    else
      chk(1'b1, "R2", "segment and offset", 0, 0);
    chk(rx_cnt == (exp_err ? 0 : 128), exp_err ? "R8" : "R5", "bytes delivered", rx_cnt,
        exp_err ? 0 : 128);
    if (poke) chk(tr_n == ex_n && mism < 0, "R9", "start while busy ignored", tr_n, ex_n);
    repeat (2) @(negedge clk);
    chk(!busy && !cmd_valid, "R1", "idle after request", {busy, cmd_valid}, 0);
  endtask

  initial begin
    #1_500_000;
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    nack_at = -1; dly = 0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !error && !rx_valid && !cmd_valid, "R1", "reset state",
        {busy, done, error, rx_valid, cmd_valid}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!busy && !cmd_valid, "R1", "idle after reset", {busy, cmd_valid}, 0);
    run_txn(0, -1, 0);
    run_txn(1, -1, 0);
    run_txn(2, -1, 0);
    run_txn(3, -1, 1);
    run_txn(255, -1, 0);
    run_txn(1, 0, 0);
    run_txn(0, 2, 0);
    for (int k = 0; k < 5; k++) run_txn(9, k, 0);
    for (int n = 0; n < 20; n++) begin
      int b, nk;
      b  = int'($urandom % 256);
      nk = (($urandom % 4) == 0) ? int'($urandom % 5) : -1;
      run_txn(b, nk, ($urandom % 5) == 0);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule